// File: doc/BRIEF.md
# Frequency-Locked Motor Speed Loop with Start and Stop Sequencing

This block closes the speed loop of one brushed DC motor channel. A tachometer pulse train from the motor (one rising edge per feedback cycle) is synchronised and measured in reference clock ticks by two counters that take turns: one times the current feedback cycle while the other holds the previous result. At every feedback edge the finished measurement is compared with a target period. The target is picked by a 4-bit speed code from sixteen speeds, 250 Hz to 1750 Hz in 100 Hz steps. The block then emits a charge strobe if the motor runs slow, or a discharge strobe if it runs fast. The strobe is as many cycles long as the period error and drives an external charge pump and integrator.

Around the loop sits a drive sequencer. A rising edge on the enable input, with a drive command present, first forces full drive for a programmed number of time units. Only then is the speed loop given control. A stop request, which is either a brake command or enable going low while the motor is driven, applies drive in the opposite direction for a programmed number of units and then shorts the bridge. One time unit is `UNIT_TICKS` reference cycles, sized to 2.048 ms of the reference clock. A 3-bit charge-pump gain code is registered and passed to the analog side.

Top module: `fll_motor_ctrl`

## Requirements
- R1: After reset the bridge output is 00 (high impedance), full_drive, loop_on and chg are 0, and dis is 1 (the motor counts as stopped).
- R2: The target period for speed code c (0 to 15) is REF_HZ / (250 + 100*c) reference cycles, rounded down.
- R3: While loop_on is 1 and the feedback period P is longer than the target T, chg is high for P-T cycles per feedback cycle and dis stays low.
- R4: While loop_on is 1 and P is shorter than T, dis is high for T-P cycles per feedback cycle and chg stays low; when P equals T neither strobe fires.
- R5: Bridge encoding: 00 high impedance, 01 forward, 10 reverse, 11 short brake; dir_rev=0 selects forward for driving.
- R6: If no feedback rising edge arrives within 2*T cycles, dis is held high and chg low until the next edge; the first edge after that yields no strobe.
- R7: With sel_a=1 and sel_b=0, a rising edge of ena in the idle or brake state gives full_drive=1 with the bridge in the dir_rev direction for start_units*UNIT_TICKS cycles, then loop_on=1 in the same direction; start_units=0 enters the loop at once.
- R8: While driving, sel_b=1 or ena=0 drives the opposite direction with full_drive=1 for rev_units*UNIT_TICKS cycles, then brake (11); rev_units=0 brakes at once.
- R9: During the reverse phase, changes on sel_a, sel_b, ena and dir_rev have no effect on the bridge or on the phase length.
- R10: Outside the reverse phase, sel_a=0 sets the bridge to 00 on the next cycle.
- R11: chg and dis strobes from the period comparison appear only while loop_on is 1; the two are never high together.
- R12: gain_out equals gain_code delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fg_in | input | 1 | Motor feedback pulse, asynchronous |
| ena | input | 1 | Drive enable; rising edge starts, low stops |
| sel_a | input | 1 | Command bit: 0 releases the bridge |
| sel_b | input | 1 | Command bit: 1 requests brake when sel_a=1 |
| dir_rev | input | 1 | Drive direction, 1 = reverse |
| spd_code | input | 4 | Speed target select |
| start_units | input | TIME_W | Forced-drive length in time units |
| rev_units | input | TIME_W | Reverse-brake length in time units |
| gain_code | input | GAIN_W | Charge-pump current select |
| bridge | output | 2 | Bridge state code |
| full_drive | output | 1 | 100 % duty forced (start or reverse phase) |
| loop_on | output | 1 | Speed loop in control |
| chg | output | 1 | Charge strobe (motor slow) |
| dis | output | 1 | Discharge strobe (fast or stopped) |
| gain_out | output | GAIN_W | Registered gain select |

## Verification
A feedback edge needs three clock edges to reach a strobe, two to synchronise it and one to register the comparison. A strobe of width W therefore starts three cycles after the edge. The bench keeps every P-T or T-P below the period minus three, so each strobe ends inside its own period. It then counts strobe cycles over three whole periods after three settling periods, and in steady state any window of that length holds exactly three strobes. Sequencer phases change one clock edge after the input that causes them and last exactly units*UNIT_TICKS edges, so the bench samples at the last edge inside a phase and at the first edge after it. The gain field is checked one edge after it is driven.

// File: rtl/fll_pkg.sv
package fll_pkg;

    localparam int SPD_BASE_HZ = 250;
    localparam int SPD_STEP_HZ = 100;
    localparam int SPD_CODES   = 16;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_START,
        PH_RUN,
        PH_REV,
        PH_BRAKE
    } phase_e;

    typedef enum logic [1:0] {
        BR_HIZ = 2'b00,
        BR_FWD = 2'b01,
        BR_REV = 2'b10,
        BR_BRK = 2'b11
    } bridge_e;

endpackage

// File: rtl/fll_period_disc.sv
module fll_period_disc
    import fll_pkg::*;
#(
    parameter int REF_HZ = 40000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fg_in,
    input  logic [3:0] spd_code,
    output logic       chg_pulse,
    output logic       dis_pulse,
    output logic       motor_stopped
);
    localparam int MAX_T = REF_HZ / SPD_BASE_HZ;
    localparam int CW    = $clog2(2 * MAX_T + 2);

    typedef struct packed {
        logic [2:0]          sync;
        logic [1:0][CW-1:0]  cnt;
        logic                act;
        logic                stopped;
        logic [CW-1:0]       pw;
        logic                up;
    } disc_t;

    disc_t d, q;
    logic [SPD_CODES-1:0][CW-1:0] tgt_tab;
    logic [CW-1:0] tgt, lim, meas;
    logic          fg_edge;

    // Target period for each speed code, fixed at elaboration
    for (genvar i = 0; i < SPD_CODES; i++) begin : g_tgt
        assign tgt_tab[i] = CW'(REF_HZ / (SPD_BASE_HZ + SPD_STEP_HZ * i));
    end

    always_comb begin
        d       = q;
        d.sync  = {q.sync[1:0], fg_in};
        fg_edge = q.sync[1] & ~q.sync[2];
        tgt     = tgt_tab[spd_code];
        lim     = {tgt[CW-2:0], 1'b0};
        meas    = q.cnt[q.act] + CW'(1);
        if (q.pw != '0) begin
            d.pw = q.pw - CW'(1);
        end
        if (fg_edge) begin
            // swap roles: the other counter starts timing the next cycle
            d.act          = ~q.act;
            d.cnt[~q.act]  = '0;
            if (q.stopped) begin
                d.stopped = 1'b0;
                d.pw      = '0;
            end else if (meas > tgt) begin
                d.pw = meas - tgt;
                d.up = 1'b1;
            end else begin
                d.pw = tgt - meas;
                d.up = 1'b0;
            end
        end else if (q.cnt[q.act] >= lim) begin
            d.stopped = 1'b1;
            d.pw      = '0;
        end else begin
            d.cnt[q.act] = q.cnt[q.act] + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.stopped <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign chg_pulse     = (q.pw != '0) &&  q.up;
    assign dis_pulse     = (q.pw != '0) && !q.up;
    assign motor_stopped = q.stopped;

endmodule

// File: rtl/fll_phase_timer.sv
module fll_phase_timer #(
    parameter int UNIT_TICKS = 82,
    parameter int VW         = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] load_val,
    output logic          done
);
    localparam int SW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

    typedef struct packed {
        logic [VW-1:0] units;
        logic [SW-1:0] sub;
    } tmr_t;

    tmr_t d, q;
    logic unit_end;

    always_comb begin
        d        = q;
        unit_end = (q.sub == SW'(UNIT_TICKS - 1));
        if (load) begin
            d.units = load_val;
            d.sub   = '0;
        end else if (q.units != '0) begin
            if (unit_end) begin
                d.sub   = '0;
                d.units = q.units - VW'(1);
            end else begin
                d.sub = q.sub + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // last cycle of the final unit
    assign done = (q.units == VW'(1)) && unit_end;

endmodule

// File: rtl/fll_drive_seq.sv
module fll_drive_seq
    import fll_pkg::*;
#(
    parameter int VW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ena,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          dir_rev,
    input  logic [VW-1:0] start_units,
    input  logic [VW-1:0] rev_units,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [VW-1:0] tmr_val,
    output phase_e        phase,
    output logic [1:0]    bridge,
    output logic          full_drive
);
    typedef struct packed {
        phase_e ph;
        logic   dir;
        logic   ena_prev;
    } seq_t;

    seq_t d, q;
    logic ena_rise;

    always_comb begin
        d          = q;
        d.ena_prev = ena;
        ena_rise   = ena & ~q.ena_prev;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (q.ph)
            PH_OFF, PH_BRAKE: begin
                if (!sel_a) begin
                    d.ph = PH_OFF;
                end else if (sel_b) begin
                    d.ph = PH_BRAKE;
                end else if (ena_rise) begin
                    d.dir = dir_rev;
                    if (start_units != '0) begin
                        d.ph     = PH_START;
                        tmr_load = 1'b1;
                        tmr_val  = start_units;
                    end else begin
                        d.ph = PH_RUN;
                    end
                end
            end
            PH_START, PH_RUN: begin
                if (!sel_a) begin
                    d.ph = PH_OFF;
                end else if (sel_b || !ena) begin
                    if (rev_units != '0) begin
                        d.ph     = PH_REV;
                        tmr_load = 1'b1;
                        tmr_val  = rev_units;
                    end else begin
                        d.ph = PH_BRAKE;
                    end
                end else if (q.ph == PH_START && tmr_done) begin
                    d.ph = PH_RUN;
                end
            end
            PH_REV: begin
                if (tmr_done) d.ph = PH_BRAKE;
            end
            default: d.ph = PH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph       <= PH_OFF;
            q.dir      <= 1'b0;
            q.ena_prev <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.ph)
            PH_START, PH_RUN: bridge = q.dir ? BR_REV : BR_FWD;
            PH_REV:           bridge = q.dir ? BR_FWD : BR_REV;
            PH_BRAKE:         bridge = BR_BRK;
            default:          bridge = BR_HIZ;
        endcase
    end

    assign phase      = q.ph;
    assign full_drive = (q.ph == PH_START) || (q.ph == PH_REV);

endmodule

// File: rtl/fll_motor_ctrl.sv
module fll_motor_ctrl
    import fll_pkg::*;
#(
    parameter int REF_HZ     = 40000,
    parameter int UNIT_TICKS = 82,
    parameter int TIME_W     = 6,
    parameter int GAIN_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fg_in,
    input  logic              ena,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic              dir_rev,
    input  logic [3:0]        spd_code,
    input  logic [TIME_W-1:0] start_units,
    input  logic [TIME_W-1:0] rev_units,
    input  logic [GAIN_W-1:0] gain_code,
    output logic [1:0]        bridge,
    output logic              full_drive,
    output logic              loop_on,
    output logic              chg,
    output logic              dis,
    output logic [GAIN_W-1:0] gain_out
);
    typedef struct packed {
        logic [GAIN_W-1:0] gain;
    } top_t;

    top_t d, q;

    logic              chg_pulse, dis_pulse, fg_stopped;
    logic              tmr_load, tmr_done;
    logic [TIME_W-1:0] tmr_val;
    phase_e            phase;

    fll_period_disc #(.REF_HZ(REF_HZ)) u_disc (
        .clk           (clk),
        .rst_n         (rst_n),
        .fg_in         (fg_in),
        .spd_code      (spd_code),
        .chg_pulse     (chg_pulse),
        .dis_pulse     (dis_pulse),
        .motor_stopped (fg_stopped)
    );

    fll_phase_timer #(.UNIT_TICKS(UNIT_TICKS), .VW(TIME_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    fll_drive_seq #(.VW(TIME_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ena         (ena),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .dir_rev     (dir_rev),
        .start_units (start_units),
        .rev_units   (rev_units),
        .tmr_done    (tmr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .phase       (phase),
        .bridge      (bridge),
        .full_drive  (full_drive)
    );

    always_comb begin
        d      = q;
        d.gain = gain_code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign loop_on  = (phase == PH_RUN);
    assign chg      = loop_on & chg_pulse;
    assign dis      = fg_stopped | (loop_on & dis_pulse);
    assign gain_out = q.gain;

endmodule

// File: rtl/fll_motor_chk.sv
module fll_motor_chk
    import fll_pkg::*;
#(
    parameter int GAIN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_a,
    input logic              chg,
    input logic              dis,
    input logic [1:0]        bridge,
    input phase_e            phase,
    input logic [GAIN_W-1:0] gain_code,
    input logic [GAIN_W-1:0] gain_out
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg && dis));

    // R12
    gain_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> gain_out == $past(gain_code));

    // R7
    start_dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && $past(phase) == PH_START) |-> $stable(bridge));

    // R8
    rev_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_REV && $past(phase) != PH_REV) |-> bridge != $past(bridge));

    // R9
    rev_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_REV |=> (phase == PH_REV || phase == PH_BRAKE));

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a && phase != PH_REV) |=> bridge == BR_HIZ);

endmodule

bind fll_motor_ctrl fll_motor_chk #(.GAIN_W(GAIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a     (sel_a),
    .chg       (chg),
    .dis       (dis),
    .bridge    (bridge),
    .phase     (phase),
    .gain_code (gain_code),
    .gain_out  (gain_out)
);

// File: tb/test_fll_motor_ctrl.sv
module test_fll_motor_ctrl;
    localparam int REF_HZ = 40000;
    localparam int UNIT   = 82;
    localparam int TW     = 6;
    localparam int GW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fg_in = 1'b0, ena = 1'b0, sel_a = 1'b0, sel_b = 1'b0, dir_rev = 1'b0;
    logic [3:0]    spd_code = '0;
    logic [TW-1:0] start_units = '0, rev_units = '0;
    logic [GW-1:0] gain_code = '0;
    logic [1:0]    bridge;
    logic          full_drive, loop_on, chg, dis;
    logic [GW-1:0] gain_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fll_motor_ctrl #(.REF_HZ(REF_HZ), .UNIT_TICKS(UNIT), .TIME_W(TW), .GAIN_W(GW)) i_fll_motor_ctrl (
        .clk(clk), .rst_n(rst_n), .fg_in(fg_in), .ena(ena), .sel_a(sel_a), .sel_b(sel_b),
        .dir_rev(dir_rev), .spd_code(spd_code), .start_units(start_units),
        .rev_units(rev_units), .gain_code(gain_code), .bridge(bridge),
        .full_drive(full_drive), .loop_on(loop_on), .chg(chg), .dis(dis), .gain_out(gain_out)
    );

    function automatic int tgt(input int c);
        return REF_HZ / (250 + 100 * c);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive n feedback periods of p cycles; count strobes from period 'skip' on
    task automatic run_periods(input int p, input int n, input int skip,
                               output int nc, output int nd);
        nc = 0;
        nd = 0;
        for (int per = 0; per < n; per++) begin
            for (int i = 0; i < p; i++) begin
                @(negedge clk);
                if (per >= skip) begin
                    if (chg) nc++;
                    if (dis) nd++;
                end
                fg_in = (i < p / 2);
            end
        end
    endtask

    task automatic loop_trial(input int code, input int p, input string tag);
        int nc, nd, t, ec, ed;
        spd_code = 4'(code);
        t  = tgt(code);
        ec = (p > t) ? 3 * (p - t) : 0;
        ed = (p < t) ? 3 * (t - p) : 0;
        run_periods(p, 6, 3, nc, nd);
        check(nc == ec, {tag, " chg cycles"}, nc, ec);
        check(nd == ed, {tag, " dis cycles"}, nd, ed);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nc, nd, lo, hi, code, p, t;
        void'($urandom(32'h1f2e3d4c));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check(bridge == 2'b00, "R1 bridge", bridge, 0);
        check(full_drive == 1'b0 && loop_on == 1'b0, "R1 full_drive/loop_on", {full_drive, loop_on}, 0);
        check(chg == 1'b0 && dis == 1'b1, "R1 chg/dis", {chg, dis}, 1);

        // R12 gain passthrough
        for (int k = 0; k < 5; k++) begin
            gain_code = GW'($urandom % 8);
            tick(1);
            check(gain_out == gain_code, "R12 gain_out", gain_out, gain_code);
        end

        // R11 no loop strobes while idle
        spd_code = 4'd3;
        run_periods(tgt(3) + 12, 6, 3, nc, nd);
        check(nc == 0 && nd == 0, "R11 idle strobes", nc + nd, 0);

        // R7 timed start, forward
        sel_a = 1'b1; start_units = 6'd3; dir_rev = 1'b0; ena = 1'b1;
        tick(1);
        check(full_drive && bridge == 2'b01, "R7 start forced forward", {full_drive, bridge}, 3'b101);
        tick(3 * UNIT - 1);
        check(full_drive && !loop_on, "R7 still forced at last unit", {full_drive, loop_on}, 2'b10);
        tick(1);
        check(loop_on && !full_drive && bridge == 2'b01, "R7 loop takes over R5", {loop_on, full_drive, bridge}, 4'b1001);

        // R3, R4, R5 directed
        loop_trial(0, tgt(0) + 20, "R3 slow");
        loop_trial(15, 15, "R4 fast");
        loop_trial(8, tgt(8), "R4 equal");

        // R2 every speed code
        for (int c = 0; c < 16; c++) loop_trial(c, tgt(c) + 5, "R2 table");

        // random trials
        for (int k = 0; k < 12; k++) begin
            code = int'($urandom % 16);
            t  = tgt(code);
            lo = (t + 3) / 2 + 2;
            hi = 2 * t - 3;
            p  = lo + int'($urandom % (hi - lo + 1));
            loop_trial(code, p, (p >= t) ? "R3 random" : "R4 random");
        end

        // R6 stalled motor
        spd_code = 4'd10;
        fg_in = 1'b0;
        tick(2 * tgt(10) + 10);
        nd = 0; nc = 0;
        for (int i = 0; i < 5; i++) begin
            tick(1);
            if (dis) nd++;
            if (chg) nc++;
        end
        check(nd == 5 && nc == 0, "R6 stall holds dis", nd, 5);
        run_periods(tgt(10) + 6, 1, 0, nc, nd);
        check(nc == 0, "R6 first edge no strobe", nc, 0);

        // R8 reverse brake with R9 ignored inputs
        rev_units = 6'd2; sel_b = 1'b1;
        tick(1);
        check(full_drive && bridge == 2'b10, "R8 reverse phase", {full_drive, bridge}, 3'b110);
        sel_a = 1'b0; sel_b = 1'b0; ena = 1'b0; dir_rev = 1'b1;
        tick(2 * UNIT - 1);
        check(bridge == 2'b10 && full_drive, "R9 inputs ignored in reverse", bridge, 2);
        tick(1);
        check(bridge == 2'b11 && !full_drive, "R8 brake after reverse", bridge, 3);
        tick(1);
        check(bridge == 2'b00, "R10 release from brake", bridge, 0);

        // R7 zero start time, reverse direction; R8 zero reverse via ena low
        sel_a = 1'b1; start_units = '0; rev_units = '0; ena = 1'b1;
        tick(1);
        check(loop_on && bridge == 2'b10, "R7 zero start reverse", {loop_on, bridge}, 3'b110);
        ena = 1'b0;
        tick(1);
        check(bridge == 2'b11 && !full_drive, "R8 zero reverse brakes", bridge, 3);

        // R10 release while running
        sel_b = 1'b0; ena = 1'b1; dir_rev = 1'b0;
        tick(1);
        check(loop_on && bridge == 2'b01, "R10 restart from brake", bridge, 1);
        sel_a = 1'b0;
        tick(1);
        check(bridge == 2'b00 && !loop_on, "R10 release while running", bridge, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule